// File: doc/BRIEF.md
# Edge-Steered Mode Configuration Latch

This block holds the configuration bits of a video output stage that are loaded from one shared mode pin. It registers the active-low sync control line and watches it for changes of level. Each change starts a short countdown; on the second rising clock edge after the change, the shared pin is sampled and the value goes into one of two configuration bits. After a low-to-high change the sample becomes the format select bit. After a high-to-low change it becomes the sync-on-all-channels bit. Which bit is loaded depends only on the direction of the latest change.

A second mode pin is static and is passed straight to the output with no register. A sticky flag shows that the format select bit has been loaded at least once since reset. Until then its value is not meaningful, because the shared pin has no defined level at power-up. A system can tie the shared pin to one level, which gives both bits the same value. It can also drive the pin from the sync line through a delay, which gives the two bits opposite values.

Top module: `mode_cfg_latch`

## Requirements
- R1: A synchronous active-high `rst` clears `fmt_sel`, `ins_all` and `fmt_valid` to 0. It also sets the internally registered sync level to 1 (inactive), so after reset the first 0 sampled on `sync_n` counts as a high-to-low change.
- R2: `m1_cfg` equals `m1` in the same cycle, through no register.
- R3: A change is detected at a rising edge E0 when the `sync_n` value sampled there differs from the value sampled at the previous edge. If E0 sampled 1 (a low-to-high change), then `m2` is sampled at edge E0+2 and appears on `fmt_sel` just after that edge, and `ins_all` keeps its value.
- R4: If E0 sampled 0 (a high-to-low change), then `m2` is sampled at E0+2 and appears on `ins_all`, and `fmt_sel` keeps its value.
- R5: `fmt_valid` goes to 1 together with the first `fmt_sel` capture after reset and stays 1 until reset. A capture into `ins_all` does not set it.
- R6: A new change detected at E0+1 or at E0+2 cancels the capture pending from E0 and starts a new countdown. Only the capture of the latest change takes place.
- R7: On every edge other than a capture edge, `m2` is ignored, and `fmt_sel` and `ins_all` hold their values.
- R8: Suppose `m2` follows the registered sync level delayed by two further clocks, so that at each capture edge it still shows the level from before the change. Then `fmt_sel` ends at 0 and `ins_all` at 1. With the inverse of that delayed level, `fmt_sel` ends at 1 and `ins_all` at 0.
- R9: With `m2` tied to one level, each of the two bits takes that level once a change of the matching direction has been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | input | 1 | Sync control, active low; its changes steer the capture |
| m1 | input | 1 | Static mode pin, used unregistered |
| m2 | input | 1 | Shared mode pin, sampled two edges after a sync change |
| m1_cfg | output | 1 | Direct copy of `m1` |
| fmt_sel | output | 1 | Format select bit, loaded after low-to-high changes |
| ins_all | output | 1 | Sync-on-all-channels bit, loaded after high-to-low changes |
| fmt_valid | output | 1 | Set once `fmt_sel` has been loaded since reset |

## Verification
The assertions assume that `sync_n`, `m1` and `m2` are synchronous to `clk` and settle before each rising edge. They also assume that reset is held for at least one edge before any sync activity is judged. The bench changes every input half a cycle away from the sampling edge and starts each run with a reset. The bench drives sync changes closer together than the countdown to exercise the restart. It also feeds `m2` values that differ on the edges next to the capture edge, and a long randomized stretch keeps to the same synchronous timing.

// File: rtl/mcl_pkg.sv
package mcl_pkg;

    typedef enum logic {
        DIR_FALL = 1'b0,
        DIR_RISE = 1'b1
    } edge_dir_e;

    typedef struct packed {
        logic fmt_sel;
        logic ins_all;
        logic fmt_valid;
    } cfg_t;

    localparam logic SYNC_IDLE = 1'b1;

    function automatic edge_dir_e dir_of(input logic new_level);
        return new_level ? DIR_RISE : DIR_FALL;
    endfunction

endpackage

// File: rtl/mcl_sync_edge.sv
module mcl_sync_edge
    import mcl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sync_n,
    output logic      edge_stb,
    output edge_dir_e edge_dir
);
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= SYNC_IDLE;
        else     sync_q <= sync_n;
    end

    assign edge_stb = (sync_n != sync_q);
    assign edge_dir = dir_of(sync_n);

endmodule

// File: rtl/mcl_capture_timer.sv
module mcl_capture_timer
    import mcl_pkg::*;
#(
    parameter int DELAY = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      edge_stb,
    input  edge_dir_e edge_dir,
    output logic      cap_stb,
    output edge_dir_e cap_dir
);
    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
    localparam logic [CW-1:0] LOAD = CW'(DELAY - 1);

    logic          armed;
    logic [CW-1:0] cnt;
    edge_dir_e     dir_q;

    assign cap_stb = armed && (cnt == '0) && !edge_stb;
    assign cap_dir = dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            cnt   <= '0;
            dir_q <= DIR_FALL;
        end else if (edge_stb) begin
            armed <= 1'b1;
            cnt   <= LOAD;
            dir_q <= edge_dir;
        end else if (cap_stb) begin
            armed <= 1'b0;
        end else if (armed && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    generate
        if (DELAY > 1) begin : g_restart_chk
            assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
                edge_stb |=> !cap_stb)
                else $error("capture fired one edge after a sync change");
        end
    endgenerate

endmodule

// File: rtl/mcl_cfg_regs.sv
module mcl_cfg_regs
    import mcl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cap_stb,
    input  edge_dir_e cap_dir,
    input  logic      m2,
    output cfg_t      cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (cap_stb) begin
            if (cap_dir == DIR_RISE) begin
                cfg.fmt_sel   <= m2;
                cfg.fmt_valid <= 1'b1;
            end else begin
                cfg.ins_all <= m2;
            end
        end
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !cap_stb |=> $stable(cfg.fmt_sel) && $stable(cfg.ins_all))
        else $error("configuration bit moved without a capture");

    assert_valid_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        cfg.fmt_valid |=> cfg.fmt_valid)
        else $error("format valid flag dropped");

endmodule

// File: rtl/mode_cfg_latch.sv
module mode_cfg_latch
    import mcl_pkg::*;
#(
    parameter int CAPTURE_DELAY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_n,
    input  logic m1,
    input  logic m2,
    output logic m1_cfg,
    output logic fmt_sel,
    output logic ins_all,
    output logic fmt_valid
);
    logic      edge_stb;
    edge_dir_e edge_dir;
    logic      cap_stb;
    edge_dir_e cap_dir;
    cfg_t      cfg;

    mcl_sync_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .sync_n   (sync_n),
        .edge_stb (edge_stb),
        .edge_dir (edge_dir)
    );

    mcl_capture_timer #(.DELAY(CAPTURE_DELAY)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .edge_stb (edge_stb),
        .edge_dir (edge_dir),
        .cap_stb  (cap_stb),
        .cap_dir  (cap_dir)
    );

    mcl_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .cap_stb (cap_stb),
        .cap_dir (cap_dir),
        .m2      (m2),
        .cfg     (cfg)
    );

    assign m1_cfg    = m1;
    assign fmt_sel   = cfg.fmt_sel;
    assign ins_all   = cfg.ins_all;
    assign fmt_valid = cfg.fmt_valid;

    assert_rise_cap_R3: assert property (@(posedge clk) disable iff (rst)
        (cap_stb && cap_dir == DIR_RISE) |=> (fmt_sel == $past(m2)) && $stable(ins_all))
        else $error("rising capture did not load format select");

    assert_fall_cap_R4: assert property (@(posedge clk) disable iff (rst)
        (cap_stb && cap_dir == DIR_FALL) |=> (ins_all == $past(m2)) && $stable(fmt_sel))
        else $error("falling capture did not load sync-on-all bit");

    assert_valid_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(fmt_valid) |-> $past(cap_stb && cap_dir == DIR_RISE))
        else $error("valid flag set without a rising capture");

    always_comb begin
        assert_m1_pass_R2: assert (m1_cfg == m1)
            else $error("static mode pin not passed through");
    end

endmodule

// File: tb/mode_cfg_latch_tb.sv
`timescale 1ns/1ps
module mode_cfg_latch_tb;

    typedef struct {
        logic  fmt;
        logic  ins;
        logic  vld;
        logic  m1v;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_n = 1'b1;
    logic m1 = 1'b0;
    logic m2 = 1'b0;
    logic m1_cfg, fmt_sel, ins_all, fmt_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t q[$];

    // bench model of the requirements
    logic e_fmt = 1'b0, e_ins = 1'b0, e_vld = 1'b0;
    logic prev_lvl = 1'b1;
    logic pend_dir = 1'b0;
    int   age = -1;

    // history of sampled sync levels for the delayed-m2 patterns
    logic h1 = 1'b1, h2 = 1'b1, h3 = 1'b1;

    always #2.5 clk = ~clk;

    mode_cfg_latch u_dut (
        .clk(clk), .rst(rst), .sync_n(sync_n), .m1(m1), .m2(m2),
        .m1_cfg(m1_cfg), .fmt_sel(fmt_sel), .ins_all(ins_all), .fmt_valid(fmt_valid)
    );

    task automatic cyc(input logic r, input logic s, input logic mv2, input logic mv1, input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        rst = r; sync_n = s; m2 = mv2; m1 = mv1;
        if (r) begin
            e_fmt = 0; e_ins = 0; e_vld = 0; prev_lvl = 1; age = -1;
        end else if (s != prev_lvl) begin
            age = 0; pend_dir = s; prev_lvl = s;
        end else if (age >= 0) begin
            age++;
            if (age == 2) begin
                if (pend_dir) begin e_fmt = mv2; e_vld = 1; end
                else e_ins = mv2;
                age = -1;
            end
        end
        h3 = h2; h2 = h1; h1 = s;
        e.fmt = e_fmt; e.ins = e_ins; e.vld = e_vld; e.m1v = mv1; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares just after each rising edge
    always @(posedge clk) begin
        #1;
        if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (fmt_sel !== e.fmt || ins_all !== e.ins || fmt_valid !== e.vld || m1_cfg !== e.m1v) begin
                fails++;
                $display("FAIL %s: got fmt=%b ins=%b vld=%b m1=%b expected fmt=%b ins=%b vld=%b m1=%b",
                         e.tag, fmt_sel, ins_all, fmt_valid, m1_cfg, e.fmt, e.ins, e.vld, e.m1v);
            end
        end
    end

    task automatic direct_check(input string tag, input logic f, input logic i);
        @(negedge clk);
        checks++;
        if (fmt_sel !== f || ins_all !== i) begin
            fails++;
            $display("FAIL %s: got fmt=%b ins=%b expected fmt=%b ins=%b", tag, fmt_sel, ins_all, f, i);
        end
    endtask

    initial begin
        // R1: reset state
        for (int k = 0; k < 3; k++) cyc(1, 1, 1, 0, "R1 reset");
        // R2: m1 passes straight through while idle
        for (int k = 0; k < 4; k++) cyc(0, 1, k[0], k[1], "R2 m1 pass");
        // R4: high-to-low change, only the E0+2 value of m2 is loaded
        cyc(0, 0, 0, 0, "R4 fall E0");
        cyc(0, 0, 0, 0, "R4 fall E1");
        cyc(0, 0, 1, 0, "R4 fall E2 capture");
        cyc(0, 0, 0, 0, "R7 hold after fall");
        cyc(0, 0, 0, 1, "R5 valid stays clear");
        // R3: low-to-high change
        cyc(0, 1, 0, 0, "R3 rise E0");
        cyc(0, 1, 0, 0, "R3 rise E1");
        cyc(0, 1, 1, 0, "R3 rise E2 capture");
        cyc(0, 1, 0, 0, "R5 valid set");
        cyc(0, 1, 1, 0, "R7 m2 ignored");
        cyc(0, 1, 0, 0, "R7 m2 ignored");
        // R6: fall then rise on the next edge; old capture cancelled
        cyc(0, 0, 0, 0, "R6 fall E0");
        cyc(0, 1, 0, 0, "R6 rise restarts");
        cyc(0, 1, 1, 0, "R6 old capture dropped");
        cyc(0, 1, 0, 0, "R6 new capture");
        cyc(0, 1, 1, 0, "R6 hold");
        // R6: change exactly on the capture edge
        cyc(0, 0, 0, 0, "R6 fall E0b");
        cyc(0, 0, 0, 0, "R6 E1b");
        cyc(0, 1, 0, 0, "R6 change on capture edge");
        cyc(0, 1, 0, 0, "R6 E1c");
        cyc(0, 1, 1, 0, "R6 capture c");
        // R1: reset with a capture pending
        cyc(0, 0, 0, 0, "R1 pending");
        cyc(1, 0, 1, 0, "R1 reset mid");
        cyc(0, 0, 1, 0, "R1 low after reset is a fall");
        cyc(0, 0, 1, 0, "R1 E1");
        cyc(0, 0, 1, 0, "R1 E2 capture");
        cyc(0, 0, 1, 0, "R1 after");
        // R8: m2 = registered sync delayed two further clocks
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 5; k++) cyc(0, 1, h3, 0, "R8 delayed");
            for (int k = 0; k < 5; k++) cyc(0, 0, h3, 0, "R8 delayed");
        end
        for (int k = 0; k < 5; k++) cyc(0, 1, h3, 0, "R8 delayed");
        direct_check("R8 delayed sync", 1'b0, 1'b1);
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 5; k++) cyc(0, 0, ~h3, 1, "R8 inverted");
            for (int k = 0; k < 5; k++) cyc(0, 1, ~h3, 1, "R8 inverted");
        end
        direct_check("R8 inverted sync", 1'b1, 1'b0);
        // R9: m2 tied high, then tied low
        for (int lv = 1; lv >= 0; lv--) begin
            for (int k = 0; k < 4; k++) cyc(0, 0, lv[0], 0, "R9 tied");
            for (int k = 0; k < 4; k++) cyc(0, 1, lv[0], 0, "R9 tied");
            direct_check("R9 tied level", lv[0], lv[0]);
        end
        // randomized stretch, all requirements via the model
        for (int k = 0; k < 400; k++) begin
            logic rs, rm2, rm1, rr;
            rs  = ($urandom_range(0, 3) == 0) ? ~sync_n : sync_n;
            rm2 = 1'($urandom);
            rm1 = 1'($urandom);
            rr  = ($urandom_range(0, 99) == 0);
            cyc(rr, rs, rm2, rm1, "R3 R4 R6 random");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule